// File: doc/BRIEF.md
# Clock Loop Operating-Mode Controller

This block supervises one clock-synthesis loop. Each cycle it samples a small set of status flags: initialization complete, selected input valid, some other input valid, phase locked and holdover history valid. From these it decides which of four operating modes the loop is in. The analog loop, phase detection, frequency measurement and input qualification all sit outside the block and reach it only as those flags.

When the selected input fails, the controller picks one of three recoveries. If another input is usable, it asks for an input switch and goes back to acquiring lock. If no input is usable, it coasts on stored frequency history when that history is valid, and falls back to free-run when it is not. A host-driven force-holdover level overrides the automatic choices. A power-up option keeps the loop parked in free-run until the host raises that level for the first time. Outputs stay disabled until initialization has completed. A fast-lock bandwidth select follows the loss-of-lock flag whenever fast-lock is enabled.

Top module: `pll_mode_ctrl`

## Requirements
- R1: While reset is asserted, mode is free-run, outEn is 0, lossOfLock is 1 and switchReq is 0. The mode encoding is 00 free-run, 01 acquiring, 10 locked, 11 holdover.
- R2: Until initDone has been sampled high, the mode stays free-run and outEn stays 0. outEn goes to 1 in the cycle after the first clock edge that samples initDone high, and it stays there until reset.
- R3: In free-run, when not parked, a sampled high selValid moves the mode to acquiring in the next cycle.
- R4: In acquiring, phaseLocked together with selValid moves the mode to locked. In locked, losing phaseLocked while selValid stays high returns the mode to acquiring.
- R5: If selValid drops while acquiring or locked and altValid is high, the mode becomes acquiring and switchReq is high for exactly that one cycle.
- R6: If selValid drops while acquiring or locked and altValid is low, the mode becomes holdover when historyValid is high and free-run when it is low. switchReq stays 0.
- R7: In holdover, a high selValid returns the mode to acquiring. If only altValid is high, the mode returns to acquiring and switchReq pulses for one cycle.
- R8: lossOfLock is 1 in every mode except locked. fastLockSel equals lossOfLock when fastLockEn is 1 and is 0 when fastLockEn is 0.
- R9: If holdFreeRunCfg is 1 when initialization completes, the mode stays in free-run regardless of selValid until hostForceHold is first sampled high.
- R10: After initialization, a sampled high hostForceHold puts the mode into holdover in the next cycle, whatever the other flags show. Once it is released, the normal rules of R3 to R7 apply from holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all flags are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| initDone | input | 1 | Initialization has completed |
| selValid | input | 1 | Currently selected input is qualified |
| altValid | input | 1 | Some other input is qualified and available |
| phaseLocked | input | 1 | Loop reports phase lock on the selected input |
| historyValid | input | 1 | Stored frequency history can be used for holdover |
| holdFreeRunCfg | input | 1 | Park in free-run after power-up until the host forces holdover |
| fastLockEn | input | 1 | Enables the fast-lock bandwidth select |
| hostForceHold | input | 1 | Host level forcing holdover while high |
| mode | output | 2 | Current operating mode (encoding in R1) |
| outEn | output | 1 | Clock outputs may be enabled |
| lossOfLock | output | 1 | Loop is not in locked mode |
| switchReq | output | 1 | One-cycle request to switch to the alternate input |
| fastLockSel | output | 1 | Select the wide fast-lock loop bandwidth |

## Verification
The assertions check several rules on every cycle. Locked is entered only after phase lock and a valid input were sampled. A switch request appears only together with acquiring mode and a previously valid alternate. A sampled host force always lands in holdover. Nothing leaves free-run before outputs are enabled, and fast-lock stays low when it is disabled. Other properties need the scenarios of the bench to show them: the three-way choice between switching, holdover and free-run on an input failure; the return from holdover; the power-up parking; and the exact cycle in which outEn rises.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_FREE = 2'b00,
    MODE_ACQ  = 2'b01,
    MODE_LOCK = 2'b10,
    MODE_HOLD = 2'b11
  } loopModeT;

  // strobes from the control decision to the state-holding datapath
  typedef struct packed {
    logic     markInit;
    logic     dropPin;
    logic     fireSwitch;
    loopModeT nextMode;
  } ctrlStrobeT;

endpackage

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm
  import pll_mode_pkg::*;
(
  input  loopModeT   curMode,
  input  logic       initSeen,
  input  logic       pinned,
  input  logic       initDone,
  input  logic       selValid,
  input  logic       altValid,
  input  logic       phaseLocked,
  input  logic       historyValid,
  input  logic       hostForceHold,
  output ctrlStrobeT strobe
);

  // recovery choice when the selected input is lost
  function automatic ctrlStrobeT failover(input logic alt, input logic hist);
    ctrlStrobeT s;
    s = '0;
    if (alt) begin
      s.fireSwitch = 1'b1;
      s.nextMode   = MODE_ACQ;
    end else if (hist) begin
      s.nextMode = MODE_HOLD;
    end else begin
      s.nextMode = MODE_FREE;
    end
    return s;
  endfunction

  always_comb begin
    strobe          = '0;
    strobe.nextMode = curMode;
    if (!initSeen) begin
      strobe.markInit = initDone;
      strobe.nextMode = MODE_FREE;
    end else if (hostForceHold) begin
      strobe.dropPin  = 1'b1;
      strobe.nextMode = MODE_HOLD;
    end else begin
      unique case (curMode)
        MODE_FREE: begin
          if (!pinned && selValid) strobe.nextMode = MODE_ACQ;
        end
        MODE_ACQ: begin
          if (!selValid)        strobe = failover(altValid, historyValid);
          else if (phaseLocked) strobe.nextMode = MODE_LOCK;
        end
        MODE_LOCK: begin
          if (!selValid)         strobe = failover(altValid, historyValid);
          else if (!phaseLocked) strobe.nextMode = MODE_ACQ;
        end
        MODE_HOLD: begin
          if (selValid) begin
            strobe.nextMode = MODE_ACQ;
          end else if (altValid) begin
            strobe.fireSwitch = 1'b1;
            strobe.nextMode   = MODE_ACQ;
          end
        end
        default: strobe.nextMode = MODE_FREE;
      endcase
    end
  end

endmodule

// File: rtl/pll_mode_state.sv
module pll_mode_state
  import pll_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrobeT strobe,
  input  logic       holdFreeRunCfg,
  input  logic       fastLockEn,
  output loopModeT   curMode,
  output logic       initSeen,
  output logic       pinned,
  output logic       switchReq,
  output logic       lossOfLock,
  output logic       fastLockSel
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode   <= MODE_FREE;
      initSeen  <= 1'b0;
      pinned    <= 1'b0;
      switchReq <= 1'b0;
    end else begin
      curMode   <= strobe.nextMode;
      switchReq <= strobe.fireSwitch;
      if (strobe.markInit) initSeen <= 1'b1;
      if (!initSeen)            pinned <= holdFreeRunCfg;
      else if (strobe.dropPin)  pinned <= 1'b0;
    end
  end

  assign lossOfLock  = (curMode != MODE_LOCK);
  assign fastLockSel = fastLockEn & lossOfLock;

endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
  import pll_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              initDone,
  input  logic              selValid,
  input  logic              altValid,
  input  logic              phaseLocked,
  input  logic              historyValid,
  input  logic              holdFreeRunCfg,
  input  logic              fastLockEn,
  input  logic              hostForceHold,
  output logic [MODE_W-1:0] mode,
  output logic              outEn,
  output logic              lossOfLock,
  output logic              switchReq,
  output logic              fastLockSel
);

  ctrlStrobeT strobe;
  loopModeT   curMode;
  logic       initSeen;
  logic       pinned;

  pll_mode_fsm uFsm (
    .curMode      (curMode),
    .initSeen     (initSeen),
    .pinned       (pinned),
    .initDone     (initDone),
    .selValid     (selValid),
    .altValid     (altValid),
    .phaseLocked  (phaseLocked),
    .historyValid (historyValid),
    .hostForceHold(hostForceHold),
    .strobe       (strobe)
  );

  pll_mode_state uState (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .holdFreeRunCfg(holdFreeRunCfg),
    .fastLockEn    (fastLockEn),
    .curMode       (curMode),
    .initSeen      (initSeen),
    .pinned        (pinned),
    .switchReq     (switchReq),
    .lossOfLock    (lossOfLock),
    .fastLockSel   (fastLockSel)
  );

  assign mode  = curMode;
  assign outEn = initSeen;

endmodule

// File: rtl/pll_mode_ctrl_chk.sv
module pll_mode_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       initDone,
  input logic       selValid,
  input logic       altValid,
  input logic       phaseLocked,
  input logic       hostForceHold,
  input logic       fastLockEn,
  input logic [1:0] mode,
  input logic       outEn,
  input logic       switchReq,
  input logic       fastLockSel
);

  a_r2_outen_needs_init: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEn) |-> $past(initDone));

  a_r2_free_before_init: assert property (@(posedge clk) disable iff (!rstN)
    !$past(outEn) |-> (mode == 2'b00));

  a_r4_lock_entry: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10 && $past(mode) != 2'b10) |-> $past(phaseLocked && selValid));

  a_r5_switch_with_acq: assert property (@(posedge clk) disable iff (!rstN)
    switchReq |-> (mode == 2'b01 && $past(altValid) && !$past(selValid)));

  a_r10_force_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hostForceHold) && $past(outEn)) |-> (mode == 2'b11));

  a_r8_fastlock_off: assert property (@(posedge clk) disable iff (!rstN)
    !fastLockEn |-> !fastLockSel);

endmodule

bind pll_mode_ctrl pll_mode_ctrl_chk uChk (
  .clk          (clk),
  .rstN         (rstN),
  .initDone     (initDone),
  .selValid     (selValid),
  .altValid     (altValid),
  .phaseLocked  (phaseLocked),
  .hostForceHold(hostForceHold),
  .fastLockEn   (fastLockEn),
  .mode         (mode),
  .outEn        (outEn),
  .switchReq    (switchReq),
  .fastLockSel  (fastLockSel)
);

// File: tb/tb_pll_mode_ctrl.sv
module tb_pll_mode_ctrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initDone = 1'b0, selValid = 1'b0, altValid = 1'b0, phaseLocked = 1'b0;
  logic historyValid = 1'b0, holdFreeRunCfg = 1'b0, fastLockEn = 1'b1, hostForceHold = 1'b0;
  logic [1:0] mode;
  logic outEn, lossOfLock, switchReq, fastLockSel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pll_mode_ctrl dut (
    .clk(clk), .rstN(rstN), .initDone(initDone), .selValid(selValid),
    .altValid(altValid), .phaseLocked(phaseLocked), .historyValid(historyValid),
    .holdFreeRunCfg(holdFreeRunCfg), .fastLockEn(fastLockEn),
    .hostForceHold(hostForceHold), .mode(mode), .outEn(outEn),
    .lossOfLock(lossOfLock), .switchReq(switchReq), .fastLockSel(fastLockSel)
  );

  // {sel, alt, lock, hist, force, expMode[1:0], expSwitch}
  localparam logic [7:0] VECS [0:21] = '{
    8'b00000_00_0, // idle in free-run
    8'b10000_01_0, // R3 free-run -> acquire
    8'b10000_01_0,
    8'b10100_10_0, // R4 acquire -> locked
    8'b10100_10_0,
    8'b10000_01_0, // R4 lock lost -> acquire
    8'b10100_10_0,
    8'b01000_01_1, // R5 switch to alternate
    8'b10000_01_0,
    8'b10100_10_0,
    8'b00010_11_0, // R6 holdover with history
    8'b00010_11_0,
    8'b01000_01_1, // R7 alternate from holdover
    8'b10100_10_0,
    8'b00000_00_0, // R6 free-run without history
    8'b10000_01_0,
    8'b00010_11_0, // R6 failure while acquiring
    8'b10000_01_0, // R7 selected input returns
    8'b10100_10_0,
    8'b10101_11_0, // R10 forced holdover
    8'b10101_11_0,
    8'b10000_01_0  // R10 release
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic checkMode(input string tag, input logic [1:0] expMode, input logic expSw);
    logic expLol;
    expLol = (expMode != 2'b10);
    chk({tag, " mode"}, mode, expMode);
    chk({tag, " switchReq"}, switchReq, expSw);
    chk({tag, " R8 lossOfLock"}, lossOfLock, expLol);
    chk({tag, " R8 fastLockSel"}, fastLockSel, expLol & fastLockEn);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 mode", mode, 0);
    chk("R1 outEn", outEn, 0);
    chk("R1 lossOfLock", lossOfLock, 1);
    chk("R1 switchReq", switchReq, 0);
    rstN = 1'b1;

    // R2 nothing moves before init
    selValid = 1'b1;
    repeat (3) tick();
    chk("R2 mode before init", mode, 0);
    chk("R2 outEn before init", outEn, 0);
    @(negedge clk);
    initDone = 1'b1;
    tick();
    chk("R2 outEn after init", outEn, 1);
    chk("R2 mode at init edge", mode, 0);

    // vector walk covering R3/R4/R5/R6/R7/R10
    for (int i = 0; i < 22; i++) begin
      @(negedge clk);
      {selValid, altValid, phaseLocked, historyValid, hostForceHold} = VECS[i][7:3];
      tick();
      checkMode($sformatf("vector %0d", i), VECS[i][2:1], VECS[i][0]);
    end

    // R8 fast-lock disabled while acquiring
    @(negedge clk);
    fastLockEn = 1'b0;
    tick();
    chk("R8 fastLockSel disabled", fastLockSel, 0);
    chk("R8 lossOfLock acquiring", lossOfLock, 1);

    // R9 parked free-run after power-up
    @(negedge clk);
    rstN = 1'b0; initDone = 1'b0; holdFreeRunCfg = 1'b1; fastLockEn = 1'b1;
    selValid = 1'b0; altValid = 1'b0; phaseLocked = 1'b0; historyValid = 1'b0;
    hostForceHold = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    initDone = 1'b1;
    tick();
    chk("R9 outEn", outEn, 1);
    @(negedge clk);
    selValid = 1'b1;
    repeat (3) tick();
    chk("R9 parked in free-run", mode, 0);
    @(negedge clk);
    hostForceHold = 1'b1;
    tick();
    chk("R9 R10 force releases park into holdover", mode, 3);
    @(negedge clk);
    hostForceHold = 1'b0;
    tick();
    chk("R10 released to acquire", mode, 1);
    @(negedge clk);
    phaseLocked = 1'b1;
    tick();
    chk("R4 lock after park", mode, 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule